// File: doc/BRIEF.md
# PUF Response Quality Evaluator

The block gathers Hamming-distance statistics over streams of response words from a physical unclonable function and turns them into three quality figures. Each accepted sample carries a tag that says what it is: a pair of responses to one challenge taken from the same instance under different conditions, a pair taken from two different instances, or a single response whose ones are counted. Per tag the block keeps a sample count and a running sum. The sum holds the popcount of the XOR of the two words, or of the single word for the ones tag.

A session opens with `start_i`, which clears all the sums. Samples are then streamed in. When `finish_i` is given, one shared restoring divider runs up to three times, one after another. It turns each mean into a normalized percentage in unsigned Q8.8, where 25600 is 100 %. From that percentage the block derives reliability from the same-instance distance, uniqueness from the cross-instance distance (best at 50 %), and randomness from the ones fraction (best at 50 %). A tag with no samples is not divided: its figure reads 0 and an error bit is raised for it.

Top module: `puf_quality_eval`

## Requirements
- R1: A sample accepted with kind_i = 0 (same-instance pair) adds popcount(word_a_i XOR word_b_i) to the same-instance sum and increments intra_cnt_o at the clock edge that accepts it.
- R2: A sample accepted with kind_i = 1 (cross-instance pair) adds popcount(word_a_i XOR word_b_i) to the cross-instance sum and increments inter_cnt_o at the same edge.
- R3: A sample accepted with kind_i = 2 (ones count) adds popcount(word_a_i) to the ones sum and increments ones_cnt_o; word_b_i has no effect.
- R4: A sample is accepted only when in_valid_i is high, busy_o is low and start_i is low. kind_i = 3, and any sample offered while busy_o is high, leave every count and sum unchanged.
- R5: Each figure uses q = floor(S * 25600 / (N * W)), where S is the sum of the tag, N its count and W the word width. reliability_o = 25600 - q of the same-instance tag.
- R6: uniqueness_o = 2q when 2q < 25600, else 51200 - 2q, with q from the cross-instance tag.
- R7: randomness_o applies the same fold as R6 to q of the ones tag.
- R8: If a tag has a zero count at evaluation, its figure is 0 and its bit of err_o is set. Bit 0 is same-instance (reliability), bit 1 is cross-instance (uniqueness), bit 2 is ones (randomness).
- R9: start_i while busy_o is low clears all counts and sums, result_valid_o and err_o on the next edge. It takes precedence over a sample offered in the same cycle.
- R10: finish_i while idle raises busy_o on the next edge and drops result_valid_o. busy_o stays high until the evaluation ends, then result_valid_o rises. busy_o and result_valid_o are never high together, and results hold until the next start_i or finish_i.
- R11: Every figure reported with result_valid_o high lies in 0..25600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open a session, clearing statistics |
| finish_i | input | 1 | Begin evaluation of the figures |
| in_valid_i | input | 1 | Sample present |
| kind_i | input | 2 | Sample tag: 0 same-instance, 1 cross-instance, 2 ones, 3 none |
| word_a_i | input | W | First response word |
| word_b_i | input | W | Second response word (pair tags only) |
| intra_cnt_o | output | CNT_W | Same-instance sample count |
| inter_cnt_o | output | CNT_W | Cross-instance sample count |
| ones_cnt_o | output | CNT_W | Ones sample count |
| busy_o | output | 1 | Evaluation in progress |
| result_valid_o | output | 1 | Figures are valid |
| err_o | output | 3 | Per-figure empty-tag flags |
| reliability_o | output | 16 | Reliability, Q8.8 percent |
| uniqueness_o | output | 16 | Uniqueness, Q8.8 percent |
| randomness_o | output | 16 | Randomness, Q8.8 percent |

## Verification
An 8-bit configuration is swept across every distance 0 through 8, one sample per tag. Each figure is then an exact multiple of 3200, which isolates the subtraction in R5 and both arms of the fold in R6 and R7, including the peak at 50 %. Sessions of pseudo-random words with tens of samples per tag give non-integer quotients, which separate a correct floor from rounding or a wrong normalization. Dedicated sessions leave one or all tags empty, offer tag 3, push samples while busy, and collide start with a sample, to separate the error path and the ignore rules from the accumulation path.

// File: rtl/puf_eval_pkg.sv
package puf_eval_pkg;
  typedef enum logic [1:0] {
    KIND_INTRA = 2'd0,
    KIND_INTER = 2'd1,
    KIND_ONES  = 2'd2,
    KIND_NONE  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_NEXT
  } state_e;

  localparam int unsigned FULL_SCALE = 25600;  // 100 % in Q8.8
  localparam int unsigned SCALE_BITS = 15;
  localparam int unsigned NUM_LANES  = 3;

  function automatic logic [15:0] fold_half(input logic [15:0] q);
    logic [16:0] d2;
    d2 = {q, 1'b0};
    if (d2 < 17'(FULL_SCALE)) fold_half = d2[15:0];
    else                      fold_half = 16'(17'(2 * FULL_SCALE) - d2);
  endfunction
endpackage

// File: rtl/puf_popcount.sv
module puf_popcount #(
  parameter int unsigned W    = 16,
  parameter int unsigned HD_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec_i,
  output logic [HD_W-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) ones_o = ones_o + HD_W'(vec_i[i]);
  end
endmodule

// File: rtl/puf_accum_lane.sv
module puf_accum_lane #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned HD_W  = 5,
  parameter int unsigned SUM_W = CNT_W + HD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [HD_W-1:0]  inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SUM_W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      sum_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
      sum_o <= '0;
    end else if (add_i) begin
      cnt_o <= cnt_o + 1'b1;
      sum_o <= sum_o + SUM_W'(inc_i);
    end
  end
endmodule

// File: rtl/puf_seq_div.sv
module puf_seq_div #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 17,
  localparam int unsigned IT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] numr_q;
  logic [IT_W-1:0]  it_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, numr_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      numr_q <= '0;
      quot_o <= '0;
      it_q   <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        den_q  <= den_i;
        numr_q <= num_i;
        quot_o <= '0;
        it_q   <= IT_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        numr_q <= numr_q << 1;
        quot_o <= {quot_o[NUM_W-2:0], fits};
        it_q   <= it_q - 1'b1;
        if (it_q == IT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/puf_quality_eval.sv
module puf_quality_eval
  import puf_eval_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             finish_i,
  input  logic             in_valid_i,
  input  logic [1:0]       kind_i,
  input  logic [W-1:0]     word_a_i,
  input  logic [W-1:0]     word_b_i,
  output logic [CNT_W-1:0] intra_cnt_o,
  output logic [CNT_W-1:0] inter_cnt_o,
  output logic [CNT_W-1:0] ones_cnt_o,
  output logic             busy_o,
  output logic             result_valid_o,
  output logic [2:0]       err_o,
  output logic [15:0]      reliability_o,
  output logic [15:0]      uniqueness_o,
  output logic [15:0]      randomness_o
);
  localparam int unsigned HD_W  = $clog2(W + 1);
  localparam int unsigned SUM_W = CNT_W + HD_W;
  localparam int unsigned DEN_W = CNT_W + HD_W;
  localparam int unsigned NUM_W = SUM_W + SCALE_BITS;

  state_e            state_q;
  logic [1:0]        sel_q;
  logic [15:0]       res_q [NUM_LANES];
  logic              idle, accept, clr;
  logic [W-1:0]      pc_vec;
  logic [HD_W-1:0]   pc_val;
  logic [CNT_W-1:0]  lane_cnt [NUM_LANES];
  logic [SUM_W-1:0]  lane_sum [NUM_LANES];
  logic [CNT_W-1:0]  cnt_sel;
  logic [SUM_W-1:0]  sum_sel;
  logic              div_start, div_done;
  logic [NUM_W-1:0]  div_quot;
  logic [15:0]       q16, metric;

  assign idle   = (state_q == ST_IDLE);
  assign clr    = idle && start_i;
  assign accept = idle && in_valid_i && !start_i && (kind_i != KIND_NONE);
  assign pc_vec = (kind_i == KIND_ONES) ? word_a_i : (word_a_i ^ word_b_i);

  puf_popcount #(.W(W), .HD_W(HD_W)) u_popcount (
    .vec_i  (pc_vec),
    .ones_o (pc_val)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    puf_accum_lane #(.CNT_W(CNT_W), .HD_W(HD_W), .SUM_W(SUM_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .add_i  (accept && (kind_i == 2'(g))),
      .inc_i  (pc_val),
      .cnt_o  (lane_cnt[g]),
      .sum_o  (lane_sum[g])
    );
  end

  always_comb begin
    case (sel_q)
      2'd0:    begin cnt_sel = lane_cnt[0]; sum_sel = lane_sum[0]; end
      2'd1:    begin cnt_sel = lane_cnt[1]; sum_sel = lane_sum[1]; end
      default: begin cnt_sel = lane_cnt[2]; sum_sel = lane_sum[2]; end
    endcase
  end

  assign div_start = (state_q == ST_LOAD) && (cnt_sel != '0);

  puf_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (NUM_W'(sum_sel) * NUM_W'(FULL_SCALE)),
    .den_i   (DEN_W'(cnt_sel) * DEN_W'(W)),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  // quotient never exceeds FULL_SCALE since sum <= count * W
  assign q16 = div_quot[15:0];

  always_comb begin
    if (sel_q == 2'd0) metric = 16'(FULL_SCALE) - q16;
    else               metric = fold_half(q16);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      sel_q          <= '0;
      err_o          <= '0;
      result_valid_o <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) res_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            err_o          <= '0;
            result_valid_o <= 1'b0;
            for (int i = 0; i < NUM_LANES; i++) res_q[i] <= '0;
          end else if (finish_i) begin
            err_o          <= '0;
            result_valid_o <= 1'b0;
            sel_q          <= '0;
            state_q        <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cnt_sel == '0) begin
            res_q[sel_q] <= '0;
            err_o[sel_q] <= 1'b1;
            state_q      <= ST_NEXT;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (div_done) begin
            res_q[sel_q] <= metric;
            state_q      <= ST_NEXT;
          end
        end
        default: begin
          if (sel_q == 2'(NUM_LANES - 1)) begin
            result_valid_o <= 1'b1;
            state_q        <= ST_IDLE;
          end else begin
            sel_q   <= sel_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
      endcase
    end
  end

  assign busy_o        = !idle;
  assign intra_cnt_o   = lane_cnt[0];
  assign inter_cnt_o   = lane_cnt[1];
  assign ones_cnt_o    = lane_cnt[2];
  assign reliability_o = res_q[0];
  assign uniqueness_o  = res_q[1];
  assign randomness_o  = res_q[2];
endmodule

// File: rtl/puf_quality_eval_chk.sv
module puf_quality_eval_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             finish_i,
  input logic             in_valid_i,
  input logic [1:0]       kind_i,
  input logic [CNT_W-1:0] intra_cnt_o,
  input logic [CNT_W-1:0] inter_cnt_o,
  input logic [CNT_W-1:0] ones_cnt_o,
  input logic             busy_o,
  input logic             result_valid_o,
  input logic [2:0]       err_o,
  input logic [15:0]      reliability_o,
  input logic [15:0]      uniqueness_o,
  input logic [15:0]      randomness_o
);
  assert_busy_valid_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && result_valid_o));

  assert_frozen_while_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(intra_cnt_o) && $stable(inter_cnt_o) && $stable(ones_cnt_o)));

  assert_kind_none_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_valid_i && !start_i && kind_i == 2'd3)
      |=> ($stable(intra_cnt_o) && $stable(inter_cnt_o) && $stable(ones_cnt_o)));

  assert_intra_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_valid_i && !start_i && kind_i == 2'd0 && !(&intra_cnt_o))
      |=> (intra_cnt_o == $past(intra_cnt_o) + 1'b1));

  assert_inter_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_valid_i && !start_i && kind_i == 2'd1 && !(&inter_cnt_o))
      |=> (inter_cnt_o == $past(inter_cnt_o) + 1'b1));

  assert_ones_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_valid_i && !start_i && kind_i == 2'd2 && !(&ones_cnt_o))
      |=> (ones_cnt_o == $past(ones_cnt_o) + 1'b1));

  assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (intra_cnt_o == '0 && inter_cnt_o == '0 && ones_cnt_o == '0
                              && !result_valid_o && err_o == 3'b000));

  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> ((!err_o[0] || (reliability_o == 16'd0 && intra_cnt_o == '0)) &&
                        (!err_o[1] || (uniqueness_o == 16'd0 && inter_cnt_o == '0)) &&
                        (!err_o[2] || (randomness_o == 16'd0 && ones_cnt_o == '0))));

  assert_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (reliability_o <= 16'd25600 && uniqueness_o <= 16'd25600
                        && randomness_o <= 16'd25600));

  assert_valid_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_valid_o) |-> $past(busy_o));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !start_i && !finish_i)
      |=> (result_valid_o && $stable(reliability_o) && $stable(uniqueness_o)
           && $stable(randomness_o) && $stable(err_o)));

  assert_finish_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && finish_i && !start_i) |=> (busy_o && !result_valid_o));
endmodule

bind puf_quality_eval puf_quality_eval_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .finish_i       (finish_i),
  .in_valid_i     (in_valid_i),
  .kind_i         (kind_i),
  .intra_cnt_o    (intra_cnt_o),
  .inter_cnt_o    (inter_cnt_o),
  .ones_cnt_o     (ones_cnt_o),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o),
  .err_o          (err_o),
  .reliability_o  (reliability_o),
  .uniqueness_o   (uniqueness_o),
  .randomness_o   (randomness_o)
);

// File: tb/puf_quality_eval_tb_top.sv
module puf_quality_eval_tb_top;
  localparam int unsigned W     = 8;
  localparam int unsigned CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             finish_i = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [1:0]       kind_i = 2'd0;
  logic [W-1:0]     word_a_i = '0;
  logic [W-1:0]     word_b_i = '0;
  logic [CNT_W-1:0] intra_cnt_o, inter_cnt_o, ones_cnt_o;
  logic             busy_o, result_valid_o;
  logic [2:0]       err_o;
  logic [15:0]      reliability_o, uniqueness_o, randomness_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int e_sum [3];
  int e_cnt [3];
  int unsigned seed = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  puf_quality_eval #(.W(W), .CNT_W(CNT_W)) dut_i (.*);

  function automatic int popc(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int q_of(input int s, input int n);
    return (s * 25600) / (n * W);
  endfunction

  function automatic int fold(input int q);
    return (2 * q < 25600) ? 2 * q : 51200 - 2 * q;
  endfunction

  function automatic logic [W-1:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[W-1:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin e_sum[i] = 0; e_cnt[i] = 0; end
  endtask

  task automatic push(input logic [1:0] k, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit track);
    @(negedge clk_i);
    in_valid_i = 1'b1; kind_i = k; word_a_i = a; word_b_i = b;
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    if (track && k != 2'd3) begin
      e_cnt[k]++;
      e_sum[k] += (k == 2'd2) ? popc(a) : popc(a ^ b);
    end
  endtask

  task automatic do_start();
    @(negedge clk_i); start_i = 1'b1;
    @(posedge clk_i); #1; start_i = 1'b0;
    model_clear();
  endtask

  task automatic do_finish();
    @(negedge clk_i); finish_i = 1'b1;
    @(posedge clk_i); #1; finish_i = 1'b0;
    @(negedge clk_i);
    while (!result_valid_o) @(negedge clk_i);
  endtask

  task automatic check_counts(input string req);
    check({req, " intra count"}, int'(intra_cnt_o), e_cnt[0]);
    check({req, " inter count"}, int'(inter_cnt_o), e_cnt[1]);
    check({req, " ones count"},  int'(ones_cnt_o),  e_cnt[2]);
  endtask

  task automatic check_metrics(input string tag);
    int exp_err = 0;
    for (int i = 0; i < 3; i++) if (e_cnt[i] == 0) exp_err |= (1 << i);
    check({"R5 reliability ", tag}, int'(reliability_o),
          e_cnt[0] == 0 ? 0 : 25600 - q_of(e_sum[0], e_cnt[0]));
    check({"R6 uniqueness ", tag}, int'(uniqueness_o),
          e_cnt[1] == 0 ? 0 : fold(q_of(e_sum[1], e_cnt[1])));
    check({"R7 randomness ", tag}, int'(randomness_o),
          e_cnt[2] == 0 ? 0 : fold(q_of(e_sum[2], e_cnt[2])));
    check({"R8 err flags ", tag}, int'(err_o), exp_err);
    check({"R10 busy low with valid ", tag}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    check_counts("reset");
    check("R10 reset valid", int'(result_valid_o), 0);
    check("R10 reset busy", int'(busy_o), 0);
    check("R8 reset err", int'(err_o), 0);

    // sweep of every distance, one sample per tag (R1 R2 R3 R5 R6 R7)
    for (int k = 0; k <= int'(W); k++) begin
      logic [W-1:0] m;
      m = W'((1 << k) - 1);
      do_start();
      push(2'd0, 8'h3C, 8'h3C ^ m, 1'b1);
      push(2'd1, 8'hA5, 8'hA5 ^ {m[3:0], m[7:4]}, 1'b1);
      push(2'd2, m, 8'h5A, 1'b1);
      check_counts("R1 R2 R3 sweep");
      do_finish();
      check_metrics($sformatf("sweep k=%0d", k));
    end

    // pseudo-random sessions with non-integer quotients
    for (int s = 0; s < 3; s++) begin
      do_start();
      for (int i = 0; i < 30 + 7 * s; i++) begin
        push(2'd0, rnd(), rnd(), 1'b1);
        push(2'd1, rnd(), rnd(), 1'b1);
        if (i % 2 == 0 || s == 1) push(2'd2, rnd(), rnd(), 1'b1);
      end
      check_counts("R1 R2 R3 random");
      do_finish();
      check_metrics($sformatf("random s=%0d", s));
    end

    // tag 3 ignored (R4)
    push(2'd3, 8'hFF, 8'h00, 1'b1);
    check_counts("R4 tag3 ignored");

    // samples during busy ignored, results held (R4 R10)
    @(negedge clk_i); finish_i = 1'b1;
    @(posedge clk_i); #1; finish_i = 1'b0;
    for (int i = 0; i < 5; i++) push(2'(i % 3), 8'hF0, 8'h0F, 1'b0);
    @(negedge clk_i);
    while (!result_valid_o) @(negedge clk_i);
    check_counts("R4 busy ignored");
    check_metrics("R10 re-evaluation");
    repeat (4) @(negedge clk_i);
    check("R10 hold", int'(result_valid_o), 1);

    // empty tags (R8)
    do_start();
    check_counts("R9 start clears");
    check("R9 valid cleared", int'(result_valid_o), 0);
    check("R9 err cleared", int'(err_o), 0);
    push(2'd0, 8'h0F, 8'h00, 1'b1);
    do_finish();
    check_metrics("R8 two empty");
    do_start();
    do_finish();
    check_metrics("R8 all empty");

    // start beats a simultaneous sample (R9)
    do_start();
    push(2'd1, 8'h11, 8'h22, 1'b1);
    @(negedge clk_i);
    start_i = 1'b1; in_valid_i = 1'b1; kind_i = 2'd2; word_a_i = 8'hFF;
    @(posedge clk_i); #1;
    start_i = 1'b0; in_valid_i = 1'b0;
    model_clear();
    check_counts("R9 start precedence");

    // ones tag ignores word_b (R3)
    push(2'd2, 8'h03, 8'hFF, 1'b1);
    push(2'd2, 8'h03, 8'h00, 1'b1);
    do_finish();
    check("R3 word_b ignored", int'(randomness_o), fold(q_of(4, 2)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule